// File: doc/BRIEF.md
# Wavefront Issue Stage with Register-File Read Arbitration

This block is the per-cycle issue stage of a GPU compute unit. It has one dispatch slot for each SIMD execution pipe and one for each memory pipe, where the memory pipes are the global-memory pipes plus the shared-memory pipes. Every cycle, each slot receives its own ready-request bitmask over all wavefronts of the unit. Each slot picks the oldest requesting wavefront, which is the lowest set bit of the mask. It records that wavefront's ID and its SIMD ID. It then reports a status update for the wavefront.

Once every slot has made its pick, a second pass gives priority to the memory pipes over the vector-register-file read ports. A memory pick takes away the pick of any other slot whose wavefront sits on the same SIMD and reads the same register-file bank. Write ports are not arbitrated here, because memory results are written back later under a separate arbiter. Dropped wavefronts are sent back to ready. Kept wavefronts are marked blocked.

All slot contents and status strobes are registered. They show the decisions for the requests seen at the previous clock edge.

Top module: `issueStage`

## Requirements
- R1: The block has NUM_SIMD+NUM_GMEM+NUM_SMEM slots. Slots 0 to NUM_SIMD-1 serve execution pipes and the remaining slots serve memory pipes. The request of slot s for wavefront w is bit `readyReq[s*NUM_WF + w]`.
- R2: A synchronous reset leaves every slot EMPTY, with ID fields at zero and no status strobe, in the cycle after the reset edge.
- R3: A slot whose request mask is all zero shows EMPTY (`slotFilled` bit low) with its wavefront and SIMD ID fields at zero.
- R4: A slot picks the lowest-numbered requesting wavefront. The wavefront ID is simd*2^WF_BITS + local slot, and `slotSimdId` equals the ID shifted right by WF_BITS.
- R5: A pick that is not dropped shows FILLED with the chosen ID, and raises that wavefront's bit of `wfSetBlocked` for exactly one cycle.
- R6: A read conflict exists when a memory slot's pick and another slot's pick lie on the same SIMD and have equal local slot numbers modulo 2^BANK_BITS. The other slot is then shown EMPTY with zero IDs, and its wavefront's bit of `wfSetReady` is raised.
- R7: Picks on different SIMDs, or on different banks, never drop each other. Two execution slots never drop each other.
- R8: Memory slots are processed in ascending index order. Each drops at most one slot, namely the lowest-indexed conflicting one still occupied. A memory slot that has already been dropped drops nothing.
- R9: A wavefront that is dropped in a cycle gets a ready strobe and no blocked strobe, even if another slot keeps it.
- R10: Every output depends only on the requests at the previous clock edge. Nothing carries over to later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| readyReq | input | NUM_SLOT*NUM_WF | Per-slot ready masks over all wavefronts |
| slotFilled | output | NUM_SLOT | Slot holds a pick this cycle |
| slotWfId | output | NUM_SLOT*IDW | Chosen wavefront ID per slot, zero when empty |
| slotSimdId | output | NUM_SLOT*SIW | SIMD of the chosen wavefront, zero when empty |
| wfSetBlocked | output | NUM_WF | One-cycle strobe marking a wavefront blocked |
| wfSetReady | output | NUM_WF | One-cycle strobe returning a dropped wavefront to ready |

## Verification
Selection and arbitration are both combinational, and they feed one rank of registers. Every slot field and status strobe is therefore due exactly one rising edge after the request masks are applied. The bench drives each request pattern on a falling edge and samples all outputs on the next falling edge. Each vector also replaces the previous one, so a value left over from an earlier vector would show up as a mismatch. Reset is checked the same way, one edge after it is applied, both at start-up and in the middle of a run with requests still active.

// File: rtl/issuePkg.sv
package issuePkg;
  typedef enum logic {
    SLOT_EMPTY  = 1'b0,
    SLOT_FILLED = 1'b1
  } slotState_e;

  // strobes from control to datapath, one per dispatch slot
  typedef struct packed {
    logic pick;
    logic drop;
  } slotStrobe_t;
endpackage

// File: rtl/oldestPick.sv
module oldestPick #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic [N-1:0] req,
  output logic         valid,
  output logic [W-1:0] idx
);
  always_comb begin
    valid = |req;
    idx   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[k]) idx = W'(k);
    end
  end
endmodule

// File: rtl/issueCtrl.sv
module issueCtrl
  import issuePkg::*;
#(
  parameter int NUM_SIMD  = 2,
  parameter int NUM_SLOT  = 4,
  parameter int NUM_WF    = 8,
  parameter int WF_BITS   = 2,
  parameter int BANK_BITS = 1,
  parameter int IDW       = 3
) (
  input  logic [NUM_SLOT*NUM_WF-1:0]     readyReq,
  output slotStrobe_t [NUM_SLOT-1:0]     strobe,
  output logic [NUM_SLOT-1:0][IDW-1:0]   pickId
);
  localparam logic [IDW-1:0] BANK_MASK = IDW'((1 << BANK_BITS) - 1);

  logic [NUM_SLOT-1:0] pickValid;

  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_pick
    oldestPick #(.N(NUM_WF), .W(IDW)) u_pick (
      .req  (readyReq[s*NUM_WF +: NUM_WF]),
      .valid(pickValid[s]),
      .idx  (pickId[s])
    );
  end

  logic [NUM_SLOT-1:0] alive;
  logic [NUM_SLOT-1:0] dropVec;

  // second pass: memory slots in ascending order, first conflict only
  always_comb begin
    logic hit;
    alive   = pickValid;
    dropVec = '0;
    for (int j = NUM_SIMD; j < NUM_SLOT; j++) begin
      hit = 1'b0;
      if (alive[j]) begin
        for (int i = 0; i < NUM_SLOT; i++) begin
          if (!hit && i != j && alive[i] &&
              ((pickId[i] >> WF_BITS) == (pickId[j] >> WF_BITS)) &&
              (((pickId[i] ^ pickId[j]) & BANK_MASK) == '0)) begin
            alive[i]   = 1'b0;
            dropVec[i] = 1'b1;
            hit        = 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    for (int s = 0; s < NUM_SLOT; s++) begin
      strobe[s].pick = pickValid[s];
      strobe[s].drop = dropVec[s];
    end
  end
endmodule

// File: rtl/issueDatapath.sv
module issueDatapath
  import issuePkg::*;
#(
  parameter int NUM_SLOT = 4,
  parameter int NUM_WF   = 8,
  parameter int IDW      = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  slotStrobe_t [NUM_SLOT-1:0]   strobe,
  input  logic [NUM_SLOT-1:0][IDW-1:0] pickId,
  output logic [NUM_SLOT-1:0]          slotFilled,
  output logic [NUM_SLOT*IDW-1:0]      slotWfId,
  output logic [NUM_WF-1:0]            wfSetBlocked,
  output logic [NUM_WF-1:0]            wfSetReady
);
  slotState_e [NUM_SLOT-1:0]     stateQ, stateN;
  logic [NUM_SLOT-1:0][IDW-1:0]  idQ, idN;
  logic [NUM_WF-1:0]             blkQ, blkN, rdyQ, rdyN;

  always_comb begin
    logic [NUM_WF-1:0] blkRaw;
    blkRaw = '0;
    rdyN   = '0;
    for (int s = 0; s < NUM_SLOT; s++) begin
      if (strobe[s].pick && !strobe[s].drop) begin
        stateN[s] = SLOT_FILLED;
        idN[s]    = pickId[s];
        blkRaw[pickId[s]] = 1'b1;
      end else begin
        stateN[s] = SLOT_EMPTY;
        idN[s]    = '0;
      end
      if (strobe[s].drop) rdyN[pickId[s]] = 1'b1;
    end
    blkN = blkRaw & ~rdyN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= {NUM_SLOT{SLOT_EMPTY}};
      idQ    <= '0;
      blkQ   <= '0;
      rdyQ   <= '0;
    end else begin
      stateQ <= stateN;
      idQ    <= idN;
      blkQ   <= blkN;
      rdyQ   <= rdyN;
    end
  end

  always_comb begin
    for (int s = 0; s < NUM_SLOT; s++) begin
      slotFilled[s]            = (stateQ[s] == SLOT_FILLED);
      slotWfId[s*IDW +: IDW]   = idQ[s];
    end
  end

  assign wfSetBlocked = blkQ;
  assign wfSetReady   = rdyQ;
endmodule

// File: rtl/issueStage.sv
module issueStage
  import issuePkg::*;
#(
  parameter int NUM_SIMD  = 2,
  parameter int NUM_GMEM  = 1,
  parameter int NUM_SMEM  = 1,
  parameter int WF_BITS   = 2,
  parameter int BANK_BITS = 1,
  localparam int NUM_SLOT = NUM_SIMD + NUM_GMEM + NUM_SMEM,
  localparam int NUM_WF   = NUM_SIMD << WF_BITS,
  localparam int IDW      = $clog2(NUM_WF),
  localparam int SIW      = (NUM_SIMD > 1) ? $clog2(NUM_SIMD) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_SLOT*NUM_WF-1:0] readyReq,
  output logic [NUM_SLOT-1:0]        slotFilled,
  output logic [NUM_SLOT*IDW-1:0]    slotWfId,
  output logic [NUM_SLOT*SIW-1:0]    slotSimdId,
  output logic [NUM_WF-1:0]          wfSetBlocked,
  output logic [NUM_WF-1:0]          wfSetReady
);
  slotStrobe_t [NUM_SLOT-1:0]   strobe;
  logic [NUM_SLOT-1:0][IDW-1:0] pickId;

  issueCtrl #(
    .NUM_SIMD(NUM_SIMD), .NUM_SLOT(NUM_SLOT), .NUM_WF(NUM_WF),
    .WF_BITS(WF_BITS), .BANK_BITS(BANK_BITS), .IDW(IDW)
  ) u_ctrl (
    .readyReq(readyReq),
    .strobe  (strobe),
    .pickId  (pickId)
  );

  issueDatapath #(.NUM_SLOT(NUM_SLOT), .NUM_WF(NUM_WF), .IDW(IDW)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .pickId      (pickId),
    .slotFilled  (slotFilled),
    .slotWfId    (slotWfId),
    .wfSetBlocked(wfSetBlocked),
    .wfSetReady  (wfSetReady)
  );

  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_simd
    assign slotSimdId[s*SIW +: SIW] = SIW'(slotWfId[s*IDW +: IDW] >> WF_BITS);
  end
endmodule

// File: rtl/issueStageChk.sv
module issueStageChk #(
  parameter int NUM_SIMD = 2,
  parameter int NUM_SLOT = 4,
  parameter int NUM_WF   = 8,
  parameter int IDW      = 3
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NUM_SLOT*NUM_WF-1:0] readyReq,
  input logic [NUM_SLOT-1:0]        slotFilled,
  input logic [NUM_SLOT*IDW-1:0]    slotWfId,
  input logic [NUM_WF-1:0]          wfSetBlocked,
  input logic [NUM_WF-1:0]          wfSetReady
);
  logic [NUM_SLOT*NUM_WF-1:0] prevReq;
  logic                       armed;
  logic                       rstD;
  logic [NUM_SLOT-1:0]        prevAny, reqAtId, lowerClear;
  logic [NUM_WF-1:0]          prevUnion, heldMask;

  always_ff @(posedge clk) begin
    prevReq <= readyReq;
    rstD    <= rst;
    armed   <= rst ? 1'b0 : 1'b1;
  end

  always_comb begin
    prevUnion = '0;
    heldMask  = '0;
    for (int s = 0; s < NUM_SLOT; s++) begin
      prevAny[s]    = |prevReq[s*NUM_WF +: NUM_WF];
      prevUnion     = prevUnion | prevReq[s*NUM_WF +: NUM_WF];
      reqAtId[s]    = prevReq[s*NUM_WF + int'(slotWfId[s*IDW +: IDW])];
      lowerClear[s] = 1'b1;
      for (int w = 0; w < NUM_WF; w++) begin
        if (w < int'(slotWfId[s*IDW +: IDW]) && prevReq[s*NUM_WF + w])
          lowerClear[s] = 1'b0;
      end
      if (slotFilled[s]) heldMask[slotWfId[s*IDW +: IDW]] = 1'b1;
    end
  end

  p_reset_clears_r2: assert property (@(posedge clk)
    rstD |-> (slotFilled == '0 && wfSetBlocked == '0 && wfSetReady == '0));

  p_ready_was_requested_r6: assert property (@(posedge clk) disable iff (rst)
    armed |-> (wfSetReady & ~prevUnion) == '0);

  p_blocked_is_held_r5: assert property (@(posedge clk) disable iff (rst)
    armed |-> (wfSetBlocked & ~heldMask) == '0);

  p_no_dual_mark_r9: assert property (@(posedge clk) disable iff (rst)
    armed |-> (wfSetBlocked & wfSetReady) == '0);

  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
    p_idle_slot_r3: assert property (@(posedge clk) disable iff (rst)
      (armed && !prevAny[s]) |-> !slotFilled[s]);

    p_empty_zero_id_r3: assert property (@(posedge clk) disable iff (rst)
      (armed && !slotFilled[s]) |-> slotWfId[s*IDW +: IDW] == '0);

    p_pick_requested_r4: assert property (@(posedge clk) disable iff (rst)
      (armed && slotFilled[s]) |-> reqAtId[s]);

    p_pick_oldest_r4: assert property (@(posedge clk) disable iff (rst)
      (armed && slotFilled[s]) |-> lowerClear[s]);

    p_drop_needs_mem_r8: assert property (@(posedge clk) disable iff (rst)
      (armed && prevAny[s] && !slotFilled[s]) |-> |slotFilled[NUM_SLOT-1:NUM_SIMD]);
  end
endmodule

bind issueStage issueStageChk #(
  .NUM_SIMD(NUM_SIMD), .NUM_SLOT(NUM_SLOT), .NUM_WF(NUM_WF), .IDW(IDW)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .readyReq    (readyReq),
  .slotFilled  (slotFilled),
  .slotWfId    (slotWfId),
  .wfSetBlocked(wfSetBlocked),
  .wfSetReady  (wfSetReady)
);

// File: tb/tb_issueStage.sv
`timescale 1ns/1ps
module tb_issueStage;
  localparam int NS  = 4;
  localparam int NW  = 8;
  localparam int IDW = 3;
  localparam int SIW = 1;
  localparam int NV  = 11;

  logic                clk = 1'b0;
  logic                rst;
  logic [NS*NW-1:0]    readyReq;
  logic [NS-1:0]       slotFilled;
  logic [NS*IDW-1:0]   slotWfId;
  logic [NS*SIW-1:0]   slotSimdId;
  logic [NW-1:0]       wfSetBlocked, wfSetReady;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  issueStage dut (
    .clk(clk), .rst(rst), .readyReq(readyReq),
    .slotFilled(slotFilled), .slotWfId(slotWfId), .slotSimdId(slotSimdId),
    .wfSetBlocked(wfSetBlocked), .wfSetReady(wfSetReady)
  );

  // {req s3,s2,s1,s0 | filled | ids s3,s2,s1,s0 | blocked | ready}
  localparam logic [63:0] VEC [NV] = '{
    {32'h00_00_30_06, 4'b0011, 3'd0, 3'd0, 3'd4, 3'd1, 8'h12, 8'h00},
    {32'h00_04_00_01, 4'b0100, 3'd0, 3'd2, 3'd0, 3'd0, 8'h04, 8'h01},
    {32'h00_08_00_01, 4'b0101, 3'd0, 3'd3, 3'd0, 3'd0, 8'h09, 8'h00},
    {32'h00_10_00_01, 4'b0101, 3'd0, 3'd4, 3'd0, 3'd0, 8'h11, 8'h00},
    {32'h00_00_04_01, 4'b0011, 3'd0, 3'd0, 3'd2, 3'd0, 8'h05, 8'h00},
    {32'h00_01_04_04, 4'b0110, 3'd0, 3'd0, 3'd2, 3'd0, 8'h01, 8'h04},
    {32'h04_01_00_00, 4'b0100, 3'd0, 3'd0, 3'd0, 3'd0, 8'h01, 8'h04},
    {32'h80_04_20_01, 4'b1100, 3'd7, 3'd2, 3'd0, 3'd0, 8'h84, 8'h21},
    {32'h01_00_00_01, 4'b1000, 3'd0, 3'd0, 3'd0, 3'd0, 8'h00, 8'h01},
    {32'h00_00_00_00, 4'b0000, 3'd0, 3'd0, 3'd0, 3'd0, 8'h00, 8'h00},
    {32'h60_80_FF_F0, 4'b0111, 3'd0, 3'd7, 3'd0, 3'd4, 8'h91, 8'h20}
  };

  function automatic string vecTag(int k);
    case (k)
      0:       return "R5";
      1:       return "R6";
      2, 3, 4: return "R7";
      5, 6, 7: return "R8";
      8:       return "R9";
      9:       return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic checkIdle(string tag);
    check(tag, "filled", 64'(slotFilled), 64'h0);
    check(tag, "ids", 64'(slotWfId), 64'h0);
    check(tag, "blocked", 64'(wfSetBlocked), 64'h0);
    check(tag, "ready", 64'(wfSetReady), 64'h0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst      = 1'b1;
    readyReq = 32'hFFFF_FFFF;
    repeat (2) @(posedge clk);
    @(negedge clk);
    checkIdle("R2");
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      logic [63:0] v;
      logic [3:0]  expFilled;
      logic [11:0] expIds;
      v         = VEC[k];
      readyReq  = v[63:32];
      expFilled = v[31:28];
      expIds    = v[27:16];
      @(posedge clk);
      @(negedge clk);
      check({vecTag(k), " R10"}, "filled", 64'(slotFilled), 64'(expFilled));
      check(vecTag(k), "ids", 64'(slotWfId), 64'(expIds));
      check(vecTag(k), "blocked", 64'(wfSetBlocked), 64'(v[15:8]));
      check(vecTag(k), "ready", 64'(wfSetReady), 64'(v[7:0]));
      for (int s = 0; s < NS; s++) begin
        // R1 R4: SIMD field follows the ID encoding
        check("R1", "simd", 64'(slotSimdId[s]), 64'(expIds[s*IDW +: IDW] >> 2));
      end
    end

    // R2: reset mid-run with requests still active
    readyReq = 32'h60_80_FF_F0;
    @(posedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    checkIdle("R2");
    rst = 1'b0;

    // R10: request withdrawn, nothing carried over
    readyReq = '0;
    @(posedge clk);
    @(negedge clk);
    checkIdle("R10");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule